// File: doc/BRIEF.md
# Predicated Quadword Load-and-Broadcast Unit

This unit carries out one vector load operation. It takes a 64-bit base value and a 64-bit index and forms an effective address from them. A predicate then decides which of two 64-bit lanes to fetch from consecutive doublewords in memory. Each active lane costs one read on a valid/ready request port and one response. The two lanes form a 128-bit quadword, and that quadword is copied across a destination vector of `VL` bits.

A lane whose predicate is off is filled with zero and never reaches memory. When the base comes from the stack pointer, the base must be aligned. An index selector of 31 is an illegal encoding. Each operation ends with a one-cycle `done` pulse. At most one fault flag is high in that cycle. When a fault flag is raised, the previously delivered vector is left untouched.

Top module: `qword_bcast_load`

## Requirements
- R1: The effective address EA is `base_val + idx_val*8`, taken modulo 2^64. Lane 0 is read from EA and lane 1 from EA+8. When both lanes are active, lane 0 is requested first.
- R2: Lane 0 is active when `pred[0]` is 1, and lane 1 is active when `pred[8]` is 1. No other predicate bit affects the addresses, the traffic or the result.
- R3: An inactive lane reads as zero in the quadword and causes no memory request.
- R4: When neither lane is active and no alignment fault applies, `done` is high in the cycle after `start` is sampled. The result is then all zeros and no request is made.
- R5: After a fault-free operation, `vec_out[128*k +: 128]` equals the quadword for every k below VL/128. Lane 0 sits in the low 64 bits of each copy.
- R6: Only one request is outstanding at a time. `req_valid` stays high with `req_addr` stable until `req_ready` is high. The lane-1 request is issued only after the lane-0 response.
- R7: When `idx_sel` is 31, the operation ends with `done` and `flt_undef` high in the cycle after `start`. It makes no request and leaves `vec_out` unchanged. This check takes priority over every other fault.
- R8: When `base_is_sp` is 1, at least one lane is active and `base_val` is not a multiple of 2^SP_ALIGN_LG (16 bytes by default), the operation ends with `done` and `flt_align` high. It makes no request and leaves `vec_out` unchanged.
- R9: When `base_is_sp` is 1 and no lane is active, the alignment check runs only if `chk_sp_idle` is 1. If the check is skipped, a misaligned base completes as in R4.
- R10: A response with `rsp_err` high ends the operation with `done` and `flt_mem` high. No further request follows and `vec_out` stays unchanged.
- R11: `done` is a single-cycle pulse. At most one of `flt_undef`, `flt_align` and `flt_mem` is high, and only together with `done`. A `start` that arrives while an operation is in flight is ignored.
- R12: While reset is held and after it is released, `done`, the fault flags and `req_valid` are 0 and `vec_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| base_val | input | 64 | Base value (the stack pointer value when `base_is_sp` is set) |
| base_is_sp | input | 1 | Base comes from the stack pointer |
| idx_val | input | 64 | Index, scaled by 8 |
| idx_sel | input | 5 | Index register selector; 31 is illegal |
| pred | input | 16 | Predicate bits; bit 0 governs lane 0 and bit 8 governs lane 1 |
| chk_sp_idle | input | 1 | Perform the stack-pointer alignment check when no lane is active |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 64 | Read request address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 64 | Read response data |
| rsp_err | input | 1 | Read response carries an error |
| done | output | 1 | Operation finished (one-cycle pulse) |
| flt_undef | output | 1 | Illegal index selector |
| flt_align | output | 1 | Stack-pointer alignment fault |
| flt_mem | output | 1 | Memory error response |
| vec_out | output | VL | Replicated destination vector |

## Verification
The hardest case to reach from the ports is a second lane request that must wait on the first response. That wait has to hold while the memory side stalls the handshake and while a new `start` arrives mid-flight. The bench reaches this case with a memory model whose ready stall and response latency are set per test. The model records every accepted address and counts any request seen while a response is still pending. One test enables both lanes, stalls `req_ready` for several cycles and pulses `start` during the stall. A further case places an error response on lane 0, so that lane 1 must then never be requested.

// File: rtl/qword_bcast_load.sv
module qword_bcast_load #(
  parameter int VL          = 512,
  parameter int SP_ALIGN_LG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [63:0]   base_val,
  input  logic          base_is_sp,
  input  logic [63:0]   idx_val,
  input  logic [4:0]    idx_sel,
  input  logic [15:0]   pred,
  input  logic          chk_sp_idle,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [63:0]   req_addr,
  input  logic          rsp_valid,
  input  logic [63:0]   rsp_data,
  input  logic          rsp_err,
  output logic          done,
  output logic          flt_undef,
  output logic          flt_align,
  output logic          flt_mem,
  output logic [VL-1:0] vec_out
);
  localparam int REP = VL / 128;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t          st;
  logic [63:0]  ea_q;
  logic         lane_q;
  logic         act1_q;
  logic [127:0] quad_w;
  logic [127:0] quad_res;

  logic [63:0]  ea_new;
  logic [1:0]   act_new;
  logic         sp_mis;
  logic [127:0] quad_next;

  assign ea_new    = base_val + {idx_val[60:0], 3'b000};
  assign act_new   = {pred[8], pred[0]};
  assign sp_mis    = base_is_sp && (|base_val[SP_ALIGN_LG-1:0]);
  assign quad_next = lane_q ? {rsp_data, quad_w[63:0]} : {quad_w[127:64], rsp_data};
  assign req_valid = (st == S_REQ);
  assign req_addr  = ea_q + (lane_q ? 64'd8 : 64'd0);
  assign vec_out   = {REP{quad_res}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ea_q      <= '0;
      lane_q    <= 1'b0;
      act1_q    <= 1'b0;
      quad_w    <= '0;
      quad_res  <= '0;
      done      <= 1'b0;
      flt_undef <= 1'b0;
      flt_align <= 1'b0;
      flt_mem   <= 1'b0;
    end else begin
      done      <= 1'b0;
      flt_undef <= 1'b0;
      flt_align <= 1'b0;
      flt_mem   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (idx_sel == 5'd31) begin
            done      <= 1'b1;
            flt_undef <= 1'b1;
          end else if (sp_mis && ((|act_new) || chk_sp_idle)) begin
            done      <= 1'b1;
            flt_align <= 1'b1;
          end else if (act_new == 2'b00) begin
            done     <= 1'b1;
            quad_res <= '0;
          end else begin
            ea_q   <= ea_new;
            act1_q <= act_new[1];
            lane_q <= ~act_new[0];
            quad_w <= '0;
            st     <= S_REQ;
          end
        end
        S_REQ: if (req_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            done    <= 1'b1;
            flt_mem <= 1'b1;
            st      <= S_IDLE;
          end else if (!lane_q && act1_q) begin
            quad_w <= quad_next;
            lane_q <= 1'b1;
            st     <= S_REQ;
          end else begin
            quad_res <= quad_next;
            done     <= 1'b1;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  a_r7_undef_fault: assert property (@(posedge clk) disable iff (!rst_n)
    start && st == S_IDLE && idx_sel == 5'd31 |=> done && flt_undef && !req_valid);

  a_r10_mem_abort: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT && rsp_valid && rsp_err |=> done && flt_mem && !req_valid);

  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flt_undef, flt_align, flt_mem}));

  a_r11_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_undef || flt_align || flt_mem) |-> done);

  a_r5_vec_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vec_out) |-> done && !flt_undef && !flt_align && !flt_mem);
endmodule

// File: tb/qword_bcast_load_tb.sv
module qword_bcast_load_tb_top;
  localparam int VL = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [63:0]   base_val = '0;
  logic          base_is_sp = 1'b0;
  logic [63:0]   idx_val = '0;
  logic [4:0]    idx_sel = 5'd3;
  logic [15:0]   pred = '0;
  logic          chk_sp_idle = 1'b0;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [63:0]   req_addr;
  logic          rsp_valid = 1'b0;
  logic [63:0]   rsp_data = '0;
  logic          rsp_err = 1'b0;
  logic          done, flt_undef, flt_align, flt_mem;
  logic [VL-1:0] vec_out;

  always #4 clk = ~clk;

  qword_bcast_load #(.VL(VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_val(base_val),
    .base_is_sp(base_is_sp), .idx_val(idx_val), .idx_sel(idx_sel), .pred(pred),
    .chk_sp_idle(chk_sp_idle), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .done(done), .flt_undef(flt_undef), .flt_align(flt_align), .flt_mem(flt_mem),
    .vec_out(vec_out));

  int nchk = 0, nfail = 0;
  logic        pend = 1'b0;
  logic [63:0] pa = '0;
  int          lat_left = 0, lat_set = 0, stall_left = 0, stall_set = 0;
  int          nreq = 0, overlap = 0;
  logic [63:0] log_a [4];
  logic [63:0] err_addr = '1;

  int            o_cyc;
  logic          o_u, o_a, o_m, o_done_after;
  logic [VL-1:0] o_vec;

  function automatic logic [63:0] mval(input logic [63:0] a);
    return (a * 64'h9E3779B97F4A7C15) ^ 64'h0000_1234_5678_ABCD;
  endfunction

  always @(negedge clk) begin
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_err   = 1'b0;
    if (pend) begin
      if (req_valid) overlap++;
      if (lat_left == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = mval(pa);
        rsp_err   = (pa == err_addr);
        pend      = 1'b0;
      end else lat_left--;
    end else if (req_valid) begin
      if (stall_left > 0) stall_left--;
      else begin
        req_ready = 1'b1;
        pend = 1'b1;
        pa = req_addr;
        lat_left = lat_set;
        if (nreq < 4) log_a[nreq] = req_addr;
        nreq++;
        stall_left = stall_set;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk_vec(input string rq, input logic [127:0] q);
    logic [127:0] bad = q;
    bit ok = 1'b1;
    for (int k = 0; k < VL/128; k++)
      if (o_vec[128*k +: 128] !== q) begin ok = 1'b0; bad = o_vec[128*k +: 128]; end
    chk(ok, rq, bad, q);
  endtask

  task automatic do_op(input logic [63:0] b, input logic sp, input logic [63:0] ix,
                       input logic [4:0] sel, input logic [15:0] p, input logic ck);
    @(negedge clk);
    base_val = b; base_is_sp = sp; idx_val = ix; idx_sel = sel; pred = p; chk_sp_idle = ck;
    nreq = 0; overlap = 0; stall_left = stall_set;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    o_cyc = 1;
    while (!done && o_cyc < 200) begin @(negedge clk); o_cyc++; end
    o_u = flt_undef; o_a = flt_align; o_m = flt_mem; o_vec = vec_out;
    @(negedge clk);
    o_done_after = done;
  endtask

  task automatic t_reset;
    chk(done === 1'b0 && req_valid === 1'b0, "R12 reset outputs", {done, req_valid}, 0);
    chk(vec_out === '0 && {flt_undef, flt_align, flt_mem} === 3'b0, "R12 reset vector", vec_out[127:0], 0);
  endtask

  task automatic t_both;
    logic [63:0] ea = 64'h1000 + (64'd5 << 3);
    stall_set = 3; lat_set = 2;
    do_op(64'h1000, 1'b0, 64'd5, 5'd2, 16'h0101, 1'b0);
    chk(nreq == 2 && log_a[0] == ea, "R1 lane0 address first", log_a[0], ea);
    chk(log_a[1] == ea + 8, "R1 lane1 address", log_a[1], ea + 8);
    chk(overlap == 0, "R6 single outstanding", overlap, 0);
    chk_vec("R5 replicated quad", {mval(ea + 8), mval(ea)});
    chk(o_done_after == 1'b0 && !o_u && !o_a && !o_m, "R11 done pulse", o_done_after, 0);
    stall_set = 0; lat_set = 0;
  endtask

  task automatic t_lane1;
    logic [63:0] ea = 64'h100 - 64'd8;
    do_op(64'h100, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 16'h0100, 1'b0);
    chk(nreq == 1 && log_a[0] == ea + 8, "R3 only lane1 requested, R1 wrap", log_a[0], ea + 8);
    chk_vec("R3 inactive lane0 zero", {mval(ea + 8), 64'd0});
  endtask

  task automatic t_lane0_noise;
    logic [63:0] ea = 64'h4000 + (64'd7 << 3);
    do_op(64'h4000, 1'b0, 64'd7, 5'd1, 16'hFEFF, 1'b0);
    chk(nreq == 1 && log_a[0] == ea, "R2 other bits ignored, lane0 only", nreq, 1);
    chk_vec("R2 lane1 zero despite set bits", {64'd0, mval(ea)});
  endtask

  task automatic t_none;
    do_op(64'h5000, 1'b0, 64'd1, 5'd1, 16'hFEFE, 1'b0);
    chk(o_cyc == 1 && nreq == 0, "R4 one cycle no traffic", {o_cyc, nreq}, {32'd1, 32'd0});
    chk_vec("R4 zero result", 128'd0);
  endtask

  task automatic t_undef;
    logic [127:0] prev;
    do_op(64'h1000, 1'b0, 64'd2, 5'd2, 16'h0101, 1'b0);
    prev = o_vec[127:0];
    do_op(64'h2008, 1'b1, 64'd2, 5'd31, 16'h0101, 1'b1);
    chk(o_cyc == 1 && o_u && !o_a && !o_m && nreq == 0, "R7 undef flagged first", {o_u, o_a, o_m}, 3'b100);
    chk_vec("R7 vector unchanged", prev);
  endtask

  task automatic t_align;
    logic [127:0] prev = o_vec[127:0];
    logic [63:0] ea = 64'h2000 + (64'd4 << 3);
    do_op(64'h2008, 1'b1, 64'd4, 5'd4, 16'h0001, 1'b0);
    chk(o_a && !o_u && !o_m && nreq == 0, "R8 misaligned sp fault", {o_u, o_a, o_m}, 3'b010);
    chk_vec("R8 vector unchanged", prev);
    do_op(64'h2000, 1'b1, 64'd4, 5'd4, 16'h0001, 1'b0);
    chk(!o_a && nreq == 1 && log_a[0] == ea, "R8 aligned sp loads", log_a[0], ea);
    chk_vec("R8 aligned sp result", {64'd0, mval(ea)});
  endtask

  task automatic t_idle_chk;
    logic [127:0] prev = o_vec[127:0];
    do_op(64'h3004, 1'b1, 64'd0, 5'd0, 16'h0000, 1'b1);
    chk(o_a && nreq == 0, "R9 idle check enabled faults", o_a, 1);
    chk_vec("R9 vector unchanged on idle fault", prev);
    do_op(64'h3004, 1'b1, 64'd0, 5'd0, 16'h0000, 1'b0);
    chk(!o_a && o_cyc == 1 && nreq == 0, "R9 idle check skipped", {o_a, o_cyc}, 1);
    chk_vec("R9 zero result when skipped", 128'd0);
  endtask

  task automatic t_err;
    logic [127:0] prev;
    logic [63:0] ea = 64'h8000 + (64'd3 << 3);
    do_op(64'h1000, 1'b0, 64'd9, 5'd2, 16'h0001, 1'b0);
    prev = o_vec[127:0];
    err_addr = ea;
    do_op(64'h8000, 1'b0, 64'd3, 5'd2, 16'h0101, 1'b0);
    chk(o_m && !o_u && !o_a, "R10 error response faults", {o_u, o_a, o_m}, 3'b001);
    chk(nreq == 1, "R10 no lane1 request after error", nreq, 1);
    chk_vec("R10 vector unchanged", prev);
    err_addr = '1;
  endtask

  task automatic t_busy;
    int dones = 0;
    logic [63:0] ea = 64'h6000 + (64'd2 << 3);
    stall_set = 4; lat_set = 1;
    @(negedge clk);
    base_val = 64'h6000; base_is_sp = 1'b0; idx_val = 64'd2; idx_sel = 5'd2;
    pred = 16'h0101; nreq = 0; overlap = 0; stall_left = stall_set;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    idx_sel = 5'd31; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (done) begin dones++; chk(!flt_undef, "R11 busy start ignored", flt_undef, 0); o_vec = vec_out; end
      @(negedge clk);
    end
    chk(dones == 1 && nreq == 2 && overlap == 0, "R11 single completion", {dones, nreq}, {32'd1, 32'd2});
    chk_vec("R11 busy op result", {mval(ea + 8), mval(ea)});
    stall_set = 0; lat_set = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_both();
    t_lane1();
    t_lane0_noise();
    t_none();
    t_undef();
    t_align();
    t_idle_chk();
    t_err();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule